// File: doc/BRIEF.md
# Dual Reference Frequency Monitor

This block watches two reference clocks that arrive asynchronously to a master clock. For each reference it counts one kind of edge over a fixed measurement window and compares the total with the count that reference's nominal frequency should give. A reference whose count lies outside a parts-per-million tolerance band is flagged on its own alarm output. Each reference has its own 2-bit frequency code, so the two inputs may run at different nominal rates.

Each reference passes through a two-flop synchroniser and an edge detector in the master-clock domain. A shared window timer marks the end of every window, and a per-channel comparator turns the count into an alarm. The expected count and the limits for every code are worked out at elaboration from the master clock rate, the window length, the tolerance and the four nominal frequencies. All of these are parameters, so a short window with scaled frequencies can stand in for the two-second production window. The frequency codes are taken while reset is held. The alarms are registered and only change when a window closes.

Top module: `dual_ref_freq_monitor`

## Requirements
- R1: The frequency code selects the nominal rate: 2'b00 selects NOM_C0 (19.44 MHz by default), 2'b01 selects NOM_C1 (8 kHz), 2'b10 selects NOM_C2 (1.544 MHz) and 2'b11 selects NOM_C3 (2.048 MHz). The expected count is floor(nominal * WIN_CYC / MCLK_HZ).
- R2: With code 2'b00 only rising edges of the reference are counted. With any other code only falling edges are counted.
- R3: The tolerance is floor(expected * PPM_LIM / 1e6). A channel's alarm is set at the end of a window when its count is below expected minus tolerance or above expected plus tolerance. A count exactly on a limit does not raise the alarm.
- R4: A channel that saw no counted edge in a window raises its alarm at the end of that window, whatever the limits are.
- R5: The alarms are updated only at the end of a window. The first window ends WIN_CYC master-clock cycles after reset is released, and each later window is WIN_CYC cycles long. Between updates the alarms hold their value.
- R6: Both alarms read 0 while reset is held and until the first window after reset has completed.
- R7: The two channels are independent. The state and stimulus of one reference never change the other channel's alarm.
- R8: Each channel's frequency code is sampled while reset is held. A change of the code input outside reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low; also loads the frequency codes |
| ref0_i | input | 1 | Reference clock 0, asynchronous to clk |
| ref1_i | input | 1 | Reference clock 1, asynchronous to clk |
| fsel0_i | input | 2 | Frequency code for reference 0 |
| fsel1_i | input | 2 | Frequency code for reference 1 |
| alarm0_o | output | 1 | Reference 0 out of tolerance in the last completed window |
| alarm1_o | output | 1 | Reference 1 out of tolerance in the last completed window |

## Verification
The bench uses nominal settings whose expected counts are one and two edges per window. Each window then carries a few hand-placed edges of a single polarity, so a design that counted the wrong edge for a code would accept a bad pattern or reject a good one. Other windows drive free-running references ten percent fast and slow, and one under one percent off, on one channel at a time. A limit applied the wrong way round, or an alarm leaking between channels, would show up on the untouched alarm. A stuck reference checks the zero-edge rule, and sampling in the middle of a window catches a design that publishes alarms before the window closes. Changing a code outside reset and then resetting shows whether a design picks up the code live instead of holding the value taken in reset.

// File: rtl/fmon_pkg.sv
// Package fmon_pkg
// Shared types and elaboration-time arithmetic for the dual reference
// frequency monitor. All functions are evaluated on constants only.
package fmon_pkg;

    typedef logic [1:0] fsel_t;

    localparam fsel_t FSEL_C0 = 2'b00;  // rising-edge code (fastest rate)
    localparam fsel_t FSEL_C1 = 2'b01;
    localparam fsel_t FSEL_C2 = 2'b10;
    localparam fsel_t FSEL_C3 = 2'b11;

    // Edges expected in one window at the nominal rate.
    function automatic longint unsigned nominal_count(
        input longint unsigned nom_hz,
        input longint unsigned mclk_hz,
        input longint unsigned win_cyc
    );
        return (nom_hz * win_cyc) / mclk_hz;
    endfunction

    // Allowed deviation in edges for a given expected count and ppm limit.
    function automatic longint unsigned tol_count(
        input longint unsigned exp_cnt,
        input longint unsigned ppm
    );
        return (exp_cnt * ppm) / 64'd1_000_000;
    endfunction

    // Larger of two values, used to size the edge counter.
    function automatic longint unsigned max2(
        input longint unsigned a,
        input longint unsigned b
    );
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fmon_sync.sv
// Module fmon_sync
// Brings one asynchronous reference into the master-clock domain with
// two flops, then flags rising and falling transitions for one cycle.
// Assumes the reference runs well below half the master clock rate.
module fmon_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o,
    output logic fall_o
);

    logic [2:0] pipe_q;

    // Synchroniser stages plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[1:0], ref_i};
        end
    end

    assign rise_o =  pipe_q[1] & ~pipe_q[2];
    assign fall_o = ~pipe_q[1] &  pipe_q[2];

endmodule

// File: rtl/fmon_window.sv
// Module fmon_window
// Free-running window timer. win_end_o is high for one cycle every
// WIN_CYC master-clock cycles, the first time WIN_CYC cycles after
// reset is released. Assumes WIN_CYC >= 2.
module fmon_window #(
    parameter longint unsigned WIN_CYC = 64'd200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end_o
);

    localparam int TMR_W = $clog2(WIN_CYC);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(WIN_CYC - 64'd1);

    logic [TMR_W-1:0] tmr_q;

    assign win_end_o = (tmr_q == LAST);

    // Count cycles within the window and wrap at its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (win_end_o) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

endmodule

// File: rtl/fmon_chan.sv
// Module fmon_chan
// One monitored channel: holds the frequency code taken during reset,
// counts the edge polarity that code calls for, and at each window end
// compares the total with the precomputed limits and latches the alarm.
// The counter saturates, so a runaway input still reads as too fast.
module fmon_chan
    import fmon_pkg::*;
#(
    parameter longint unsigned MCLK_HZ = 64'd100_000_000,
    parameter longint unsigned WIN_CYC = 64'd200_000_000,
    parameter longint unsigned PPM_LIM = 64'd12,
    parameter longint unsigned NOM_C0  = 64'd19_440_000,
    parameter longint unsigned NOM_C1  = 64'd8_000,
    parameter longint unsigned NOM_C2  = 64'd1_544_000,
    parameter longint unsigned NOM_C3  = 64'd2_048_000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  fsel_t sel_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  win_end_i,
    output logic  alarm_o
);

    localparam longint unsigned EXP0 = nominal_count(NOM_C0, MCLK_HZ, WIN_CYC);
    localparam longint unsigned EXP1 = nominal_count(NOM_C1, MCLK_HZ, WIN_CYC);
    localparam longint unsigned EXP2 = nominal_count(NOM_C2, MCLK_HZ, WIN_CYC);
    localparam longint unsigned EXP3 = nominal_count(NOM_C3, MCLK_HZ, WIN_CYC);
    localparam longint unsigned TOL0 = tol_count(EXP0, PPM_LIM);
    localparam longint unsigned TOL1 = tol_count(EXP1, PPM_LIM);
    localparam longint unsigned TOL2 = tol_count(EXP2, PPM_LIM);
    localparam longint unsigned TOL3 = tol_count(EXP3, PPM_LIM);
    localparam longint unsigned MAX_HI =
        max2(max2(EXP0 + TOL0, EXP1 + TOL1), max2(EXP2 + TOL2, EXP3 + TOL3));
    localparam int CNT_W = $clog2(MAX_HI + 64'd2);

    localparam logic [CNT_W-1:0] LO0 = CNT_W'(EXP0 - TOL0);
    localparam logic [CNT_W-1:0] LO1 = CNT_W'(EXP1 - TOL1);
    localparam logic [CNT_W-1:0] LO2 = CNT_W'(EXP2 - TOL2);
    localparam logic [CNT_W-1:0] LO3 = CNT_W'(EXP3 - TOL3);
    localparam logic [CNT_W-1:0] HI0 = CNT_W'(EXP0 + TOL0);
    localparam logic [CNT_W-1:0] HI1 = CNT_W'(EXP1 + TOL1);
    localparam logic [CNT_W-1:0] HI2 = CNT_W'(EXP2 + TOL2);
    localparam logic [CNT_W-1:0] HI3 = CNT_W'(EXP3 + TOL3);

    fsel_t            code_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] lim_lo;
    logic [CNT_W-1:0] lim_hi;
    logic             edge_hit;
    logic             out_of_band;
    logic             alarm_q;

    // Pick the counted polarity and the limits for the held code.
    always_comb begin
        edge_hit = (code_q == FSEL_C0) ? rise_i : fall_i;
        case (code_q)
            FSEL_C0: begin lim_lo = LO0; lim_hi = HI0; end
            FSEL_C1: begin lim_lo = LO1; lim_hi = HI1; end
            FSEL_C2: begin lim_lo = LO2; lim_hi = HI2; end
            default: begin lim_lo = LO3; lim_hi = HI3; end
        endcase
    end

    // Next count, including an edge seen in the window's last cycle.
    always_comb begin
        if (&cnt_q) begin
            cnt_nxt = cnt_q;
        end else begin
            cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, edge_hit};
        end
        out_of_band = (cnt_nxt == '0) || (cnt_nxt < lim_lo) || (cnt_nxt > lim_hi);
    end

    // Load the code in reset; count, then judge and clear at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= sel_i;
            cnt_q   <= '0;
            alarm_q <= 1'b0;
        end else if (win_end_i) begin
            alarm_q <= out_of_band;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_nxt;
        end
    end

    assign alarm_o = alarm_q;

endmodule

// File: rtl/dual_ref_freq_monitor.sv
// Module dual_ref_freq_monitor
// Top of the dual reference frequency monitor: one shared window timer
// and, per reference, a synchroniser and a measuring channel. Both
// channels close their windows on the same master-clock cycle.
module dual_ref_freq_monitor
    import fmon_pkg::*;
#(
    parameter longint unsigned MCLK_HZ = 64'd100_000_000,
    parameter longint unsigned WIN_CYC = 64'd200_000_000,
    parameter longint unsigned PPM_LIM = 64'd12,
    parameter longint unsigned NOM_C0  = 64'd19_440_000,
    parameter longint unsigned NOM_C1  = 64'd8_000,
    parameter longint unsigned NOM_C2  = 64'd1_544_000,
    parameter longint unsigned NOM_C3  = 64'd2_048_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref0_i,
    input  logic       ref1_i,
    input  logic [1:0] fsel0_i,
    input  logic [1:0] fsel1_i,
    output logic       alarm0_o,
    output logic       alarm1_o
);

    localparam int N_CH = 2;

    logic              win_end;
    logic [N_CH-1:0]   ref_v;
    fsel_t             sel_v [N_CH];
    logic [N_CH-1:0]   rise_v;
    logic [N_CH-1:0]   fall_v;
    logic [N_CH-1:0]   alarm_v;

    assign ref_v    = {ref1_i, ref0_i};
    assign sel_v[0] = fsel0_i;
    assign sel_v[1] = fsel1_i;
    assign alarm0_o = alarm_v[0];
    assign alarm1_o = alarm_v[1];

    fmon_window #(
        .WIN_CYC (WIN_CYC)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end_o (win_end)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        fmon_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_i  (ref_v[ch]),
            .rise_o (rise_v[ch]),
            .fall_o (fall_v[ch])
        );

        fmon_chan #(
            .MCLK_HZ (MCLK_HZ),
            .WIN_CYC (WIN_CYC),
            .PPM_LIM (PPM_LIM),
            .NOM_C0  (NOM_C0),
            .NOM_C1  (NOM_C1),
            .NOM_C2  (NOM_C2),
            .NOM_C3  (NOM_C3)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_i     (sel_v[ch]),
            .rise_i    (rise_v[ch]),
            .fall_i    (fall_v[ch]),
            .win_end_i (win_end),
            .alarm_o   (alarm_v[ch])
        );
    end

endmodule

// File: rtl/dual_ref_freq_monitor_chk.sv
// Module dual_ref_freq_monitor_chk
// Checker bound to the top: window period, alarm hold between windows
// and quiet alarms before the first window closes.
module dual_ref_freq_monitor_chk #(
    parameter longint unsigned WIN_CYC = 64'd200_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic win_end,
    input logic alarm0,
    input logic alarm1
);

    localparam int GAP_W = $clog2(WIN_CYC) + 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(WIN_CYC - 64'd1);

    logic [GAP_W-1:0] gap_q;
    logic             seen_end_q;

    // Cycles since reset release or the last window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (win_end) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Remembers that at least one window has closed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_end_q <= 1'b0;
        end else if (win_end) begin
            seen_end_q <= 1'b1;
        end
    end

    // R5
    win_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> (gap_q == GAP_LAST));

    // R5
    win_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == GAP_LAST) |-> win_end);

    // R5
    alarm0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(alarm0));

    // R5
    alarm1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(alarm1));

    // R6
    first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_end_q |-> (!alarm0 && !alarm1));

endmodule

bind dual_ref_freq_monitor dual_ref_freq_monitor_chk #(
    .WIN_CYC (WIN_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_end (win_end),
    .alarm0  (alarm0_o),
    .alarm1  (alarm1_o)
);

// File: tb/sim_dual_ref_freq_monitor.sv
`timescale 1ns/1ps
// Directed bench for dual_ref_freq_monitor with scaled nominal rates:
// code 00 -> 2 edges/window, 01 -> 1, 10 -> 100 (+-2), 11 -> 200 (+-4).
module sim_dual_ref_freq_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fsel0 = 2'b00;
    logic [1:0] fsel1 = 2'b01;
    logic       man0 = 1'b0;
    logic       man1 = 1'b1;
    logic       g0 = 1'b0;
    logic       g1 = 1'b0;
    logic       gen0_en = 1'b0;
    logic       gen1_en = 1'b0;
    int         half0 = 250;
    int         half1 = 125;
    logic       ref0;
    logic       ref1;
    logic       alarm0;
    logic       alarm1;
    int         n_chk = 0;
    int         n_bad = 0;

    assign ref0 = gen0_en ? g0 : man0;
    assign ref1 = gen1_en ? g1 : man1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_ref_freq_monitor #(
        .MCLK_HZ (64'd100_000_000),
        .WIN_CYC (64'(W)),
        .PPM_LIM (64'd20_000),
        .NOM_C0  (64'd40_000),
        .NOM_C1  (64'd20_000),
        .NOM_C2  (64'd2_000_000),
        .NOM_C3  (64'd4_000_000)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref0_i   (ref0),
        .ref1_i   (ref1),
        .fsel0_i  (fsel0),
        .fsel1_i  (fsel1),
        .alarm0_o (alarm0),
        .alarm1_o (alarm1)
    );

    // Free-running reference generators.
    initial forever begin
        if (gen0_en) begin #(half0); g0 = ~g0; end else #1;
    end
    initial forever begin
        if (gen1_en) begin #(half1); g1 = ~g1; end else #1;
    end

    task automatic check_pair(input string req, input logic e0, input logic e1);
        n_chk++;
        if (alarm0 !== e0 || alarm1 !== e1) begin
            n_bad++;
            $display("FAIL %s: alarms=%b%b expected %b%b", req, alarm0, alarm1, e0, e1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_window();
        repeat (W) @(posedge clk);
        #1;
    endtask

    // R6 and R4: quiet until first window, then dead inputs alarm.
    task automatic t_first_window();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_pair("R6 during reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (W/2) @(posedge clk);
        #1;
        check_pair("R6 inside first window", 1'b0, 1'b0);
        repeat (W - W/2) @(posedge clk);
        #1;
        check_pair("R4 no edges in window", 1'b1, 1'b1);
    endtask

    // R2 and R1: single-polarity edge patterns on codes 00 and 01.
    task automatic t_polarity();
        fork
            begin
                repeat (100) @(negedge clk);
                man0 = 1'b1;
                repeat (20) @(negedge clk);
                man0 = 1'b0;
                repeat (20) @(negedge clk);
                man0 = 1'b1;
                man1 = 1'b0;
            end
            wait_window();
        join
        check_pair("R2 two rises on 00, one fall on 01", 1'b0, 1'b0);
        fork
            begin
                repeat (100) @(negedge clk);
                man0 = 1'b0;
                repeat (20) @(negedge clk);
                man0 = 1'b1;
                repeat (20) @(negedge clk);
                man0 = 1'b0;
                man1 = 1'b1;
            end
            wait_window();
        join
        check_pair("R2 one rise on 00, no fall on 01", 1'b1, 1'b1);
    endtask

    // R1, R3, R5, R7 and R4 with free-running references.
    task automatic t_rates();
        fsel0 = 2'b10;
        fsel1 = 2'b11;
        half0 = 250;
        half1 = 125;
        gen0_en = 1'b1;
        gen1_en = 1'b1;
        do_reset();
        wait_window();
        wait_window();
        check_pair("R1 nominal rates on codes 10 and 11", 1'b0, 1'b0);
        half0 = 227;
        repeat (W/2) @(posedge clk);
        #1;
        check_pair("R5 no update mid window", 1'b0, 1'b0);
        repeat (W - W/2) @(posedge clk);
        #1;
        wait_window();
        check_pair("R3 R7 ref0 ten percent fast", 1'b1, 1'b0);
        half0 = 250;
        half1 = 139;
        wait_window();
        wait_window();
        check_pair("R3 R7 ref1 ten percent slow", 1'b0, 1'b1);
        half0 = 248;
        half1 = 125;
        wait_window();
        wait_window();
        check_pair("R3 small offset inside tolerance", 1'b0, 1'b0);
        gen1_en = 1'b0;
        wait_window();
        wait_window();
        check_pair("R4 R7 ref1 stuck", 1'b0, 1'b1);
        gen1_en = 1'b1;
        wait_window();
        wait_window();
        check_pair("R7 ref1 restored", 1'b0, 1'b0);
    endtask

    // R8: code change outside reset ignored, applied after reset.
    task automatic t_code_latch();
        fsel0 = 2'b11;
        wait_window();
        wait_window();
        check_pair("R8 code change ignored without reset", 1'b0, 1'b0);
        do_reset();
        wait_window();
        wait_window();
        check_pair("R8 R1 new code after reset", 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_first_window();
        t_polarity();
        t_rates();
        t_code_latch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule